// File: doc/BRIEF.md
# Cycle-Counting CPU Interrupt Timer

This block is a one-shot down-counter that sits on an 8-bit CPU bus and counts bus cycles, marked by falling edges of the CPU phase clock (M2). Software arms it by writing a cycle count to one register address. When that many bus cycles have gone by, the block sets an expiry flag and drives the level-sensitive, active-low interrupt line. Reading the same address reports the flag and acknowledges it. Writing zero stops a running count without an interrupt.

The timer never reloads itself. To get a periodic tick, such as a sample-rate event for an audio converter, the interrupt handler writes the period again on every interrupt. Writing 1 produces an interrupt one bus cycle later, which software uses to start a chain of handler-driven periods. The M2 input is synchronised into the system clock domain. Each bus access takes effect on the M2 falling edge that ends it.

Top module: `irqt_timer`

## Requirements
- R1: A write (cpu_rw=0) of a non-zero value N to address 16'h5209 loads the count. The interrupt (irq_n=0) appears at the N-th M2 falling edge after the one that ends the write, and not at any earlier edge.
- R2: A write of 8'h00 to 16'h5209 stops a running count. No interrupt follows, however many bus cycles pass.
- R3: The timer is one-shot. After it expires and the flag is acknowledged, no further interrupt occurs until a new write is made.
- R4: During a read (cpu_rw=1) of 16'h5209 with M2 high, cpu_rdata_oe is 1 and cpu_rdata carries the expiry flag in bit 7, with bits 6..0 at zero. Reads of any other address leave cpu_rdata_oe at 0.
- R5: irq_n stays low while the flag is set. A read of 16'h5209 clears the flag, and irq_n returns high after the M2 falling edge that ends the read.
- R6: A write while the timer is running restarts it with the new count. A flag that is already pending stays set through that write.
- R7: When a read acknowledge and an expiry fall on the same M2 edge, the expiry wins and the flag is left set. The read itself returns 8'h00.
- R8: When a write falls on the edge where the old count would have expired, the write wins. The old count raises no interrupt, and the new count runs from that edge.
- R9: Reads and writes to any address other than 16'h5209 change neither the count nor the flag.
- R10: Reset (rst_n=0) stops the timer and clears the flag, so irq_n=1 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than M2 |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_m2 | input | 1 | CPU phase clock; a falling edge ends a bus cycle |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data, status byte |
| cpu_rdata_oe | output | 1 | Read data drive enable |
| irq_n | output | 1 | Level interrupt request, active low |

## Verification
Two pairs of functions can land on the same M2 falling edge. A read acknowledge can coincide with an expiry, and a restarting write can coincide with the edge on which the old count would have expired. The bench provokes the first by writing 1 and reading in the very next bus cycle. It then expects the read to return zero and irq_n to be low afterwards. It provokes the second by writing 2, letting one idle cycle pass, and writing 3. It then expects irq_n to stay high for two more cycles and to fall on the third. The single-count behaviour is swept over many counts, checking irq_n after every bus cycle against the arithmetic rule that the interrupt appears once the number of elapsed cycles reaches N.

// File: rtl/irqt_pkg.sv
package irqt_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned FLAG_BIT = 7;

  typedef logic [DATA_W-1:0] byte_t;

  // Counter step: one bus cycle consumed.
  function automatic byte_t count_step(input byte_t cnt);
    return cnt - byte_t'(1);
  endfunction

  // True when the next tick brings the count to zero.
  function automatic logic count_is_last(input byte_t cnt);
    return cnt == byte_t'(1);
  endfunction

  // Status byte as seen by a read.
  function automatic byte_t status_byte(input logic flag);
    byte_t b;
    b = '0;
    b[FLAG_BIT] = flag;
    return b;
  endfunction
endpackage

// File: rtl/irqt_m2_edge.sv
module irqt_m2_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic m2_in,
  output logic m2_level,
  output logic m2_fall
);
  localparam int unsigned SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SH_W-2:0], m2_in};
  end

  assign m2_level = sh_q[SYNC_STAGES-1];
  assign m2_fall  = sh_q[SYNC_STAGES] & ~sh_q[SYNC_STAGES-1];
endmodule

// File: rtl/irqt_bus_decode.sv
module irqt_bus_decode
  import irqt_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h5209
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rw,
  input  byte_t             wdata,
  input  logic              m2_level,
  input  logic              m2_fall,
  input  logic              flag,
  output logic              wr_evt,
  output logic              rd_evt,
  output byte_t             load_val,
  output byte_t             rdata,
  output logic              rdata_oe
);
  logic sel;

  assign sel      = (addr == REG_ADDR);
  assign wr_evt   = m2_fall & sel & ~rw;
  assign rd_evt   = m2_fall & sel & rw;
  assign load_val = wdata;
  assign rdata_oe = m2_level & sel & rw;
  assign rdata    = rdata_oe ? status_byte(flag) : '0;
endmodule

// File: rtl/irqt_down_counter.sv
module irqt_down_counter
  import irqt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  load,
  input  byte_t load_val,
  output logic  running,
  output byte_t count,
  output logic  expire
);
  byte_t cnt_q;
  logic  run_q;

  // A load on the same tick overrides the old count's expiry.
  assign expire  = tick & run_q & ~load & count_is_last(cnt_q);
  assign running = run_q;
  assign count   = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      run_q <= (load_val != '0);
    end else if (tick && run_q) begin
      cnt_q <= count_step(cnt_q);
      if (count_is_last(cnt_q)) run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/irqt_timer.sv
module irqt_timer
  import irqt_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 16'h5209,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rw,
  input  logic              cpu_m2,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              cpu_rdata_oe,
  output logic              irq_n
);
  logic  m2_level;
  logic  m2_fall;
  logic  wr_evt;
  logic  rd_evt;
  logic  expire_evt;
  logic  timer_running;
  byte_t timer_count;
  byte_t load_val;
  logic  flag_q;

  irqt_m2_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .m2_in    (cpu_m2),
    .m2_level (m2_level),
    .m2_fall  (m2_fall)
  );

  irqt_bus_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
    .addr     (cpu_addr),
    .rw       (cpu_rw),
    .wdata    (cpu_wdata),
    .m2_level (m2_level),
    .m2_fall  (m2_fall),
    .flag     (flag_q),
    .wr_evt   (wr_evt),
    .rd_evt   (rd_evt),
    .load_val (load_val),
    .rdata    (cpu_rdata),
    .rdata_oe (cpu_rdata_oe)
  );

  irqt_down_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (m2_fall),
    .load     (wr_evt),
    .load_val (load_val),
    .running  (timer_running),
    .count    (timer_count),
    .expire   (expire_evt)
  );

  // Expiry outranks acknowledge; writes leave the flag alone.
  always_ff @(posedge clk) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (expire_evt) flag_q <= 1'b1;
    else if (rd_evt)     flag_q <= 1'b0;
  end

  assign irq_n = ~flag_q;
endmodule

// File: rtl/irqt_checker.sv
module irqt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       flag,
  input logic       expire,
  input logic       rd_ack,
  input logic       wr_evt,
  input logic [7:0] wr_data,
  input logic       running,
  input logic       data_oe,
  input logic [7:0] data_out
);
  AST_SET_NEEDS_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(expire)); // R1

  AST_ZERO_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && wr_data == 8'h00) |=> !running); // R2

  AST_HALT_AFTER_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !running); // R3

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (data_out[6:0] == 7'd0)); // R4

  AST_CLEAR_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(rd_ack)); // R5

  AST_WRITE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> $stable(flag)); // R6

  AST_EXPIRE_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && expire) |=> flag); // R7

  AST_WRITE_BEATS_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |-> !expire); // R8
endmodule

bind irqt_timer irqt_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .flag     (flag_q),
  .expire   (expire_evt),
  .rd_ack   (rd_evt),
  .wr_evt   (wr_evt),
  .wr_data  (load_val),
  .running  (timer_running),
  .data_oe  (cpu_rdata_oe),
  .data_out (cpu_rdata)
);

// File: tb/irqt_timer_bench.sv
`timescale 1ns/1ps
module irqt_timer_bench;
  localparam logic [15:0] REG = 16'h5209;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic        cpu_rw = 1'b1;
  logic        cpu_m2 = 1'b0;
  logic [7:0]  cpu_wdata = 8'h00;
  logic [7:0]  cpu_rdata;
  logic        cpu_rdata_oe;
  logic        irq_n;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irqt_timer u_irqt_timer (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
    .cpu_m2(cpu_m2), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_rdata_oe(cpu_rdata_oe), .irq_n(irq_n)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One bus cycle: set up with M2 low, raise M2, sample, lower M2, settle.
  task automatic bus(input logic [15:0] a, input logic rw, input logic [7:0] d,
                     output logic [7:0] rd, output logic oe);
    @(negedge clk);
    cpu_addr = a; cpu_rw = rw; cpu_wdata = d; cpu_m2 = 1'b0;
    repeat (2) @(negedge clk);
    cpu_m2 = 1'b1;
    repeat (5) @(negedge clk);
    rd = cpu_rdata; oe = cpu_rdata_oe;
    cpu_m2 = 1'b0;
    repeat (5) @(negedge clk);
    cpu_addr = 16'h0000; cpu_rw = 1'b1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] rd; logic oe;
    bus(a, 1'b0, d, rd, oe);
  endtask

  task automatic rdreg(input logic [15:0] a, output logic [7:0] rd, output logic oe);
    bus(a, 1'b1, 8'h00, rd, oe);
  endtask

  task automatic idle(input int n);
    logic [7:0] rd; logic oe;
    for (int i = 0; i < n; i++) bus(16'h0000, 1'b1, 8'h00, rd, oe);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (4) @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #900000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic oe;
    do_reset();

    // R10 reset state
    check("R10 irq after reset", irq_n, 1);
    rdreg(REG, rd, oe);
    check("R4 reset read data", rd, 8'h00);
    check("R4 reset read oe", oe, 1);

    // R1 sweep: irq low iff elapsed cycles k >= N; R5 ack; R3 one-shot
    for (int n = 1; n <= 24; n++) begin
      wr(REG, 8'(n));
      for (int k = 1; k <= n + 2; k++) begin
        idle(1);
        check($sformatf("R1 N=%0d k=%0d", n, k), irq_n, (k >= n) ? 0 : 1);
      end
      rdreg(REG, rd, oe);
      check($sformatf("R4 flag read N=%0d", n), rd, 8'h80);
      check($sformatf("R5 ack N=%0d", n), irq_n, 1);
      rdreg(REG, rd, oe);
      check($sformatf("R5 second read N=%0d", n), rd, 8'h00);
    end
    idle(30);
    check("R3 no reload", irq_n, 1);

    // R1 large count
    wr(REG, 8'hFF);
    idle(254);
    check("R1 N=255 k=254", irq_n, 1);
    idle(1);
    check("R1 N=255 k=255", irq_n, 0);
    rdreg(REG, rd, oe);

    // R2 stop
    wr(REG, 8'd6); idle(3); wr(REG, 8'h00); idle(20);
    check("R2 stopped", irq_n, 1);

    // R6 restart
    wr(REG, 8'd10); idle(5); wr(REG, 8'd3); idle(2);
    check("R6 restart early", irq_n, 1);
    idle(1);
    check("R6 restart fires", irq_n, 0);
    // R6 pending flag kept through write
    wr(REG, 8'd5);
    check("R6 flag kept", irq_n, 0);
    rdreg(REG, rd, oe);
    check("R6 flag read", rd, 8'h80);
    check("R6 cleared", irq_n, 1);
    idle(3);
    check("R6 second early", irq_n, 1);
    idle(1);
    check("R6 second fires", irq_n, 0);
    rdreg(REG, rd, oe);

    // R7 ack and expiry on one edge
    wr(REG, 8'd1);
    rdreg(REG, rd, oe);
    check("R7 read data", rd, 8'h00);
    check("R7 flag survives", irq_n, 0);
    rdreg(REG, rd, oe);
    check("R7 later ack", irq_n, 1);

    // R8 write on expiry edge
    wr(REG, 8'd2); idle(1); wr(REG, 8'd3); idle(2);
    check("R8 no old expiry", irq_n, 1);
    idle(1);
    check("R8 new count", irq_n, 0);

    // R9 other addresses
    rdreg(16'h5208, rd, oe);
    check("R9 other read oe", oe, 0);
    rdreg(16'h5219, rd, oe);
    check("R9 other read keeps flag", irq_n, 0);
    rdreg(REG, rd, oe);
    wr(16'h5208, 8'd2); wr(16'h4209, 8'd1); idle(8);
    check("R9 other write ignored", irq_n, 1);
    wr(REG, 8'd4); wr(16'hD209, 8'h00); idle(3);
    check("R9 stop elsewhere ignored", irq_n, 0);

    // R10 reset clears flag and stops a run
    do_reset();
    check("R10 flag cleared", irq_n, 1);
    wr(REG, 8'd4); idle(1); do_reset(); idle(8);
    check("R10 run stopped", irq_n, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule